// File: doc/BRIEF.md
# Shared-Switch Operand Loader with Decimal Text Formatter

This block sits in front of a small arithmetic unit on a board that offers only one 4-bit switch bank. Three push buttons decide where the switch value goes: one button stores it as the first operand, one as the second operand, and one as the operation code. The operation code keeps only the three low switch bits. Each button passes through a synchroniser and a rising-edge detector, so one press loads its register once, however long the button is held.

The block also turns the two operands and the arithmetic unit's result into text for a character display. Each 4-bit value becomes a two-digit decimal number. Each digit is sent as its ASCII code. The ten characters go out on one 80-bit bus: first operand, space, second operand, space, result, then spaces to fill the line. The result field follows the `alu_res` input combinationally. The arithmetic unit and the panel driver are outside this block.

Top module: `switch_loader_display`

## Requirements
- R1: If `btn_a` rises before clock edge E1, the pulse is high after edge E2 and `opa` takes the value of `sw` at edge E3. `opa` shows the old value until E3.
- R2: A button held high for many cycles loads its register exactly once. Later changes to `sw` while the button is still held do not reach the register.
- R3: `btn_b` loads `sw` into `opb` with the same three-edge timing as R1.
- R4: `btn_op` loads `sw[2:0]` into `opsel`. Switch bit 3 is discarded.
- R5: A load changes only the register that belongs to the pressed button. The other two registers keep their values.
- R6: A synchronous active-high `rst` clears `opa`, `opb` and `opsel` to zero. The display then shows "00" in both operand fields.
- R7: Character layout, with character 0 in `disp_chars[79:72]` and character 9 in `disp_chars[7:0]`:
  - characters 0 and 1 hold the first operand's tens and units digits;
  - characters 3 and 4 hold the second operand's tens and units digits;
  - characters 6 and 7 hold the result's tens and units digits;
  - characters 2, 5, 8 and 9 are space (0x20).
- R8: Each value v from 0 to 15 is shown as two ASCII digits (0x30 plus the digit). The tens digit is '0' for v < 10 and '1' for v ≥ 10. The units digit is v mod 10.
- R9: The result field follows `alu_res` in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers load on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sw | input | 4 | Shared switch value |
| btn_a | input | 1 | Raw button that loads the first operand |
| btn_b | input | 1 | Raw button that loads the second operand |
| btn_op | input | 1 | Raw button that loads the operation code |
| alu_res | input | 4 | Result from the external arithmetic unit |
| opa | output | 4 | Stored first operand |
| opb | output | 4 | Stored second operand |
| opsel | output | 3 | Stored operation code |
| disp_chars | output | 80 | Ten ASCII characters, character 0 in the top byte |

## Verification
The bench samples the stored value one cycle before and one cycle after the expected load edge. A design with a missing or extra synchroniser stage would therefore load a cycle early or late. It changes the switches while a button is still held. A level-triggered load instead of an edge-triggered one would follow the switches and fail. Operation loads use values with bit 3 set, to catch a register that keeps the discarded bit. Operands and results of 9, 10 and 15 exercise the boundary where the tens digit changes, and random values cover the rest of the range and the separator positions.

// File: rtl/swcap_pkg.sv
package swcap_pkg;

    localparam int OPND_W  = 4;
    localparam int SEL_W   = 3;
    localparam int CHAR_W  = 8;
    localparam int NUM_TGT = 3;

    localparam logic [CHAR_W-1:0] CH_SPACE = 8'h20;
    localparam logic [CHAR_W-1:0] CH_ZERO  = 8'h30;

    typedef enum int {TGT_A = 0, TGT_B = 1, TGT_OP = 2} target_e;

    typedef struct packed {
        logic [OPND_W-1:0] a;
        logic [OPND_W-1:0] b;
        logic [SEL_W-1:0]  op;
    } opnd_regs_t;

    typedef struct packed {
        logic [3:0] tens;
        logic [3:0] ones;
    } bcd2_t;

    function automatic bcd2_t to_bcd2(input logic [7:0] v);
        bcd2_t r;
        r.tens = 4'((v / 8'd10) % 8'd10);
        r.ones = 4'(v % 8'd10);
        return r;
    endfunction

    function automatic logic [2*CHAR_W-1:0] bcd_to_chars(input bcd2_t b);
        return {CH_ZERO + {4'h0, b.tens}, CH_ZERO + {4'h0, b.ones}};
    endfunction

endpackage

// File: rtl/btn_edge.sv
module btn_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_raw,
    output logic pulse
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], btn_raw};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign pulse = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/operand_bank.sv
module operand_bank
    import swcap_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [OPND_W-1:0]   sw,
    input  logic [NUM_TGT-1:0]  ld,
    output opnd_regs_t          regs
);
    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else begin
            if (ld[TGT_A])  regs.a  <= sw;
            if (ld[TGT_B])  regs.b  <= sw;
            if (ld[TGT_OP]) regs.op <= sw[SEL_W-1:0];
        end
    end
endmodule

// File: rtl/char_packer.sv
module char_packer
    import swcap_pkg::*;
#(
    parameter int NUM_CHARS = 10
) (
    input  logic [OPND_W-1:0]          val_a,
    input  logic [OPND_W-1:0]          val_b,
    input  logic [OPND_W-1:0]          val_r,
    output logic [NUM_CHARS*CHAR_W-1:0] chars
);
    localparam int NUM_FLD  = 3;
    localparam int FLD_CH   = 3;
    localparam int PAD_CH   = NUM_CHARS - NUM_FLD * FLD_CH;
    localparam int TOP      = NUM_CHARS * CHAR_W - 1;

    logic [7:0] fld [NUM_FLD];

    assign fld[0] = 8'(val_a);
    assign fld[1] = 8'(val_b);
    assign fld[2] = 8'(val_r);

    for (genvar f = 0; f < NUM_FLD; f++) begin : g_fld
        localparam int HI = TOP - f * FLD_CH * CHAR_W;
        assign chars[HI -: 2*CHAR_W]          = bcd_to_chars(to_bcd2(fld[f]));
        assign chars[HI - 2*CHAR_W -: CHAR_W] = CH_SPACE;
    end

    if (PAD_CH > 0) begin : g_pad
        assign chars[PAD_CH*CHAR_W-1:0] = {PAD_CH{CH_SPACE}};
    end
endmodule

// File: rtl/switch_loader_display.sv
module switch_loader_display
    import swcap_pkg::*;
#(
    parameter int NUM_CHARS   = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [OPND_W-1:0]           sw,
    input  logic                        btn_a,
    input  logic                        btn_b,
    input  logic                        btn_op,
    input  logic [OPND_W-1:0]           alu_res,
    output logic [OPND_W-1:0]           opa,
    output logic [OPND_W-1:0]           opb,
    output logic [SEL_W-1:0]            opsel,
    output logic [NUM_CHARS*CHAR_W-1:0] disp_chars
);
    logic [NUM_TGT-1:0] btn_vec;
    logic [NUM_TGT-1:0] ld_pulse;
    opnd_regs_t         regs;

    assign btn_vec = {btn_op, btn_b, btn_a};

    for (genvar i = 0; i < NUM_TGT; i++) begin : g_btn
        btn_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk     (clk),
            .rst     (rst),
            .btn_raw (btn_vec[i]),
            .pulse   (ld_pulse[i])
        );
    end

    operand_bank u_bank (
        .clk  (clk),
        .rst  (rst),
        .sw   (sw),
        .ld   (ld_pulse),
        .regs (regs)
    );

    char_packer #(.NUM_CHARS(NUM_CHARS)) u_pack (
        .val_a (regs.a),
        .val_b (regs.b),
        .val_r (alu_res),
        .chars (disp_chars)
    );

    assign opa   = regs.a;
    assign opb   = regs.b;
    assign opsel = regs.op;
endmodule

// File: rtl/switch_loader_chk.sv
module switch_loader_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] sw,
    input logic [2:0] ld,
    input logic [3:0] opa,
    input logic [3:0] opb,
    input logic [2:0] opsel
);
    p_load_a_r1: assert property (@(posedge clk) disable iff (rst)
        ld[0] |=> opa == $past(sw));

    p_one_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        (ld != 3'b000) |=> ((ld & $past(ld)) == 3'b000));

    p_load_b_r3: assert property (@(posedge clk) disable iff (rst)
        ld[1] |=> opb == $past(sw));

    p_low_bits_r4: assert property (@(posedge clk) disable iff (rst)
        ld[2] |=> opsel == $past(sw[2:0]));

    p_hold_a_r5: assert property (@(posedge clk) disable iff (rst)
        !ld[0] |=> $stable(opa));

    p_hold_b_r5: assert property (@(posedge clk) disable iff (rst)
        !ld[1] |=> $stable(opb));

    p_hold_op_r5: assert property (@(posedge clk) disable iff (rst)
        !ld[2] |=> $stable(opsel));
endmodule

bind switch_loader_display switch_loader_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .sw    (sw),
    .ld    (ld_pulse),
    .opa   (opa),
    .opb   (opb),
    .opsel (opsel)
);

// File: tb/test_switch_loader_display.sv
module test_switch_loader_display;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  sw = '0;
    logic        btn_a = 1'b0, btn_b = 1'b0, btn_op = 1'b0;
    logic [3:0]  alu_res = '0;
    logic [3:0]  opa, opb;
    logic [2:0]  opsel;
    logic [79:0] disp_chars;

    int n_checks = 0;
    int n_errors = 0;
    logic [3:0] m_a = '0, m_b = '0;
    logic [2:0] m_op = '0;

    always #2.5 clk = ~clk;

    switch_loader_display i_switch_loader_display (
        .clk(clk), .rst(rst), .sw(sw), .btn_a(btn_a), .btn_b(btn_b),
        .btn_op(btn_op), .alu_res(alu_res), .opa(opa), .opb(opb),
        .opsel(opsel), .disp_chars(disp_chars)
    );

    function automatic logic [15:0] dig2(input int v);
        return {8'(32'h30 + v / 10), 8'(32'h30 + v % 10)};
    endfunction

    function automatic logic [79:0] exp_disp(input int a, input int b, input int r);
        return {dig2(a), 8'h20, dig2(b), 8'h20, dig2(r), 8'h20, 8'h20};
    endfunction

    task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check({req, " opa"}, 80'(opa), 80'(m_a));
        check({req, " opb"}, 80'(opb), 80'(m_b));
        check({req, " opsel"}, 80'(opsel), 80'(m_op));
        check({req, " R7 R8 disp"}, disp_chars, exp_disp(int'(m_a), int'(m_b), int'(alu_res)));
    endtask

    task automatic set_btn(input int tgt, input logic v);
        case (tgt)
            0: btn_a = v;
            1: btn_b = v;
            default: btn_op = v;
        endcase
    endtask

    // press: drive at a negedge, load lands on the third following posedge
    task automatic press(input int tgt, input logic [3:0] v, input bit timing_chk);
        @(negedge clk);
        sw = v;
        set_btn(tgt, 1'b1);
        repeat (2) @(negedge clk);
        if (timing_chk) check_all("R1 R3 before load edge");
        @(negedge clk);
        case (tgt)
            0: m_a = v;
            1: m_b = v;
            default: m_op = v[2:0];
        endcase
        if (timing_chk) check_all("R1 R3 R4 R5 at load edge");
        sw = ~v;  // R2: held button, switches move
        repeat (4) @(negedge clk);
        if (timing_chk) check_all("R2 held button no reload");
        set_btn(tgt, 1'b0);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        alu_res = 4'd9;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check_all("R6 reset state");

        press(0, 4'd10, 1'b1);
        press(1, 4'd15, 1'b1);
        press(2, 4'b1101, 1'b1);  // R4: bit 3 dropped
        check({"R4 opsel low bits"}, 80'(opsel), 80'(3'b101));
        press(2, 4'b1000, 1'b1);
        check({"R4 opsel bit3 only"}, 80'(opsel), 80'(3'b000));

        // R9: result field tracks alu_res in the same cycle
        @(negedge clk);
        alu_res = 4'd10;
        #1;
        check("R9 result immediate", disp_chars[31:16], 16'h3130);
        alu_res = 4'd15;
        #1;
        check("R9 R8 result 15", disp_chars[31:16], 16'h3135);
        check("R7 separators", {disp_chars[63:56], disp_chars[39:32], disp_chars[15:0]}, 80'h20202020);
        press(0, 4'd9, 1'b1);
        check("R8 value 9", disp_chars[79:64], 16'h3039);

        // R6: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_a = '0; m_b = '0; m_op = '0;
        #1;
        check_all("R6 mid-run reset");
        check("R6 zero fields", disp_chars[79:32], {16'h3030, 8'h20, 16'h3030, 8'h20});

        for (int i = 0; i < 60; i++) begin
            int tgt;
            logic [3:0] v;
            tgt = int'($urandom % 3);
            v = 4'($urandom);
            alu_res = 4'($urandom);
            press(tgt, v, 1'b0);
            check_all("R1 R3 R4 R5 R8 random");
        end

        finish_run();
    end
endmodule